// File: doc/BRIEF.md
# Status Snapshot Latch Controller

This block decides when a set of live status bits is copied into status registers that software reads. While software reads several registers one after another, the live bits may keep changing. The copy is therefore taken at one chosen instant, so that all the registers software reads belong to the same moment.

Two events start a copy. The first is a bus write to a reserved latch address; the data on the bus plays no part. The second is a rising edge on the interrupt line, and it counts only while the interrupt-latch enable is high. A source select chooses which line is watched: the local interrupt or an interrupt line shared between chips. On a secondary chip the shared line is chosen, so that every chip copies its status on the same edge.

The interrupt line is taken through a short synchronizer and its edge is found in the system clock domain. Reads are served from the held copy through an address decode.

Top module: `stat_snap_ctrl`

## Requirements
- R1: A cycle with `wr_en` high and `wr_addr` equal to `LATCH_ADDR` (default 8'h80) copies all of `live_status` into all held registers on that clock edge. The new values are readable, and `snap_taken` is high, in the cycle that follows. This is far inside the 200 ns limit, which is 10 cycles at 50 MHz.
- R2: A write to any other address, and a cycle with `wr_en` low, changes no held register.
- R3: With `irq_latch_en` high, a low-to-high change of the selected interrupt line takes exactly one copy. If the line first reads high at clock edge k, the copy is made at edge k+SYNC_STAGES and holds `live_status` as it stood just before that edge.
- R4: With `irq_latch_en` low, interrupt edges take no copy, and latch writes still take a copy.
- R5: An interrupt line that stays high, or that falls, takes no further copy.
- R6: `irq_src_sel` = 0 watches `irq_local`; `irq_src_sel` = 1 watches `irq_shared`. The line that is not selected has no effect.
- R7: When a latch write and a qualified interrupt edge fall in the same cycle, one copy is taken. In the cycle after it, `snap_taken` and `snap_coincide` are both high.
- R8: `rd_data` returns held register i when `rd_addr` = `RD_BASE`+i (default base 8'h90, with i from 0 to NUM_REGS-1). It never returns the live bits. Any other read address returns 0.
- R9: After reset every held register reads 0, and `snap_taken` and `snap_coincide` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Bus write address |
| rd_addr | input | ADDR_W | Bus read address |
| rd_data | output | REG_W | Held register selected by rd_addr |
| live_status | input | NUM_REGS*REG_W | Live status bits; register i is slice [i*REG_W +: REG_W] |
| irq_local | input | 1 | Interrupt of this chip |
| irq_shared | input | 1 | Interrupt line shared between chips |
| irq_src_sel | input | 1 | 0: watch irq_local, 1: watch irq_shared |
| irq_latch_en | input | 1 | Lets interrupt rising edges take a copy |
| snap_taken | output | 1 | High the cycle after a copy was made |
| snap_coincide | output | 1 | High the cycle after a copy that both triggers requested |

## Verification
The bench builds the block with its defaults: four 16-bit registers, 8-bit addresses and two synchronizer stages. It derives the interrupt latency from SYNC_STAGES, so a deeper synchronizer moves its expectations along with the design. With two stages, an interrupt edge becomes a copy three edges after it is driven. That short distance lets the directed cases place a latch write in exactly the cycle where the edge qualifies, which is the coincidence case. The random phase switches the source select and the enable between edges, to show that the line not selected and a disabled edge take no copy.

// File: rtl/snap_pkg.sv
// Package: shared types of the status snapshot controller.
// Assumes: nothing beyond IEEE 1800-2017.
package snap_pkg;
    // The two requests that can start a copy.
    typedef struct packed {
        logic wr_req;
        logic irq_req;
    } snap_trig_t;
endpackage

// File: rtl/snap_wr_decode.sv
// Module: snap_wr_decode
// Purpose: recognises a bus write to the latch address. The data bus is
//          not looked at; only the strobe and the address matter.
// Assumes: wr_en is a single-cycle strobe in the clk domain.
module snap_wr_decode #(
    parameter int ADDR_W                 = 8,
    parameter logic [ADDR_W-1:0] LATCH_ADDR = 8'h80
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              latch_hit
);
    // Address match, qualified by the strobe.
    always_comb begin
        latch_hit = wr_en && (wr_addr == LATCH_ADDR);
    end
endmodule

// File: rtl/snap_irq_edge.sv
// Module: snap_irq_edge
// Purpose: selects the local or the shared interrupt line, passes it through
//          SYNC_STAGES flops, and flags one cycle for each low-to-high change.
// Assumes: the interrupt lines may be asynchronous to clk; SYNC_STAGES >= 1.
module snap_irq_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_local,
    input  logic irq_shared,
    input  logic irq_src_sel,
    output logic irq_rise
);
    logic                   irq_sel;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Source selection: 1 follows the shared line.
    always_comb begin
        irq_sel = irq_src_sel ? irq_shared : irq_local;
    end

    // Synchronizer chain, one flop per stage.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= irq_sel;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    // Previous synchronized level, used for the edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // A rise is a high level now after a low level one cycle earlier.
    always_comb begin
        irq_rise = sync_q[SYNC_STAGES-1] && !prev_q;
    end

    // A rise lasts a single cycle, so a held-high line gives no second copy.
    assert_single_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rise |=> !irq_rise);
endmodule

// File: rtl/snap_bank.sv
// Module: snap_bank
// Purpose: holds NUM_REGS status registers and loads all of them from the
//          live bits, in the same cycle, when snap_en is high.
// Assumes: live_status is stable in the clk domain around a copy.
module snap_bank #(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 16,
    localparam int BUS_W   = NUM_REGS * REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap_en,
    input  logic [BUS_W-1:0] live_status,
    output logic [BUS_W-1:0] held_status
);
    // One register slice per status word.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)       held_status[r*REG_W +: REG_W] <= '0;
            else if (snap_en) held_status[r*REG_W +: REG_W] <= live_status[r*REG_W +: REG_W];
        end
    end

    // Without a copy request the held registers must not move.
    assert_hold_no_snap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_en |=> $stable(held_status));
endmodule

// File: rtl/snap_rd_mux.sv
// Module: snap_rd_mux
// Purpose: returns the held register addressed by rd_addr, or 0 when the
//          address falls outside the register window.
// Assumes: RD_BASE + NUM_REGS fits in ADDR_W bits.
module snap_rd_mux #(
    parameter int NUM_REGS             = 4,
    parameter int REG_W                = 16,
    parameter int ADDR_W               = 8,
    parameter logic [ADDR_W-1:0] RD_BASE = 8'h90,
    localparam int BUS_W               = NUM_REGS * REG_W
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [BUS_W-1:0]  held_status,
    output logic [REG_W-1:0]  rd_data
);
    logic [NUM_REGS-1:0] hit;

    // One address comparator per register.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_hit
        always_comb begin
            hit[r] = (rd_addr == RD_BASE + ADDR_W'(r));
        end
    end

    // AND-OR selection of the addressed word.
    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            rd_data = rd_data | (held_status[r*REG_W +: REG_W] & {REG_W{hit[r]}});
        end
    end

    // The comparators are distinct addresses, so at most one may hit.
    always_comb begin
        assert_one_hit_R8: assert ($onehot0(hit));
    end
endmodule

// File: rtl/stat_snap_ctrl.sv
// Module: stat_snap_ctrl (top)
// Purpose: takes a consistent snapshot of the live status bits, on a latch
//          write or on a qualified interrupt rising edge, and serves reads
//          from that snapshot.
// Assumes: the bus is synchronous to clk; interrupt lines may be asynchronous.
module stat_snap_ctrl
    import snap_pkg::*;
#(
    parameter int NUM_REGS                  = 4,
    parameter int REG_W                     = 16,
    parameter int ADDR_W                    = 8,
    parameter int SYNC_STAGES               = 2,
    parameter logic [ADDR_W-1:0] LATCH_ADDR = 8'h80,
    parameter logic [ADDR_W-1:0] RD_BASE    = 8'h90,
    localparam int BUS_W                    = NUM_REGS * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic [BUS_W-1:0]  live_status,
    input  logic              irq_local,
    input  logic              irq_shared,
    input  logic              irq_src_sel,
    input  logic              irq_latch_en,
    output logic              snap_taken,
    output logic              snap_coincide
);
    snap_trig_t       trig;
    logic             latch_hit;
    logic             irq_rise;
    logic             snap_en;
    logic [BUS_W-1:0] held_status;

    snap_wr_decode #(.ADDR_W(ADDR_W), .LATCH_ADDR(LATCH_ADDR)) u_dec (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .latch_hit (latch_hit)
    );

    snap_irq_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_local   (irq_local),
        .irq_shared  (irq_shared),
        .irq_src_sel (irq_src_sel),
        .irq_rise    (irq_rise)
    );

    // Collect both requests; the interrupt one is gated by the enable.
    always_comb begin
        trig.wr_req  = latch_hit;
        trig.irq_req = irq_rise && irq_latch_en;
        snap_en      = trig.wr_req || trig.irq_req;
    end

    snap_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .snap_en     (snap_en),
        .live_status (live_status),
        .held_status (held_status)
    );

    snap_rd_mux #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .ADDR_W(ADDR_W),
                  .RD_BASE(RD_BASE)) u_rd (
        .rd_addr     (rd_addr),
        .held_status (held_status),
        .rd_data     (rd_data)
    );

    // Flags that report, one cycle later, a copy and a double request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_taken    <= 1'b0;
            snap_coincide <= 1'b0;
        end else begin
            snap_taken    <= snap_en;
            snap_coincide <= trig.wr_req && trig.irq_req;
        end
    end

    // A latch write is always followed by a reported copy.
    assert_write_snaps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        latch_hit |=> snap_taken);

    // With the interrupt path disabled and no latch write, no copy follows.
    assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_latch_en && !latch_hit) |=> !snap_taken);

    // A double request is reported together with one copy.
    assert_coincide_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snap_coincide |-> snap_taken);

    // A qualified edge is always followed by a reported copy.
    assert_irq_snaps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rise && irq_latch_en) |=> snap_taken);
endmodule

// File: tb/stat_snap_ctrl_tb_top.sv
// Bench: stat_snap_ctrl_tb_top. Directed corner cases and then seeded random
// stimulus, checked against a cycle model built from the requirements.
module stat_snap_ctrl_tb_top;
    localparam int NR   = 4;
    localparam int RW   = 16;
    localparam int AW   = 8;
    localparam int SS   = 2;
    localparam int BW   = NR * RW;
    localparam logic [AW-1:0] LATCH = 8'h80;
    localparam logic [AW-1:0] BASE  = 8'h90;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [RW-1:0] rd_data;
    logic [BW-1:0] live_status = '0;
    logic irq_local = 1'b0, irq_shared = 1'b0, irq_src_sel = 1'b0, irq_latch_en = 1'b1;
    logic snap_taken, snap_coincide;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;
    string tag   = "R9";

    // Model state
    logic [SS-1:0] m_sync = '0;
    logic          m_prev = 1'b0;
    logic [RW-1:0] m_held [NR];
    logic          m_taken = 1'b0, m_coin = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    stat_snap_ctrl #(.NUM_REGS(NR), .REG_W(RW), .ADDR_W(AW), .SYNC_STAGES(SS),
                     .LATCH_ADDR(LATCH), .RD_BASE(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .rd_addr(rd_addr), .rd_data(rd_data), .live_status(live_status),
        .irq_local(irq_local), .irq_shared(irq_shared), .irq_src_sel(irq_src_sel),
        .irq_latch_en(irq_latch_en), .snap_taken(snap_taken), .snap_coincide(snap_coincide)
    );

    function automatic logic [RW-1:0] exp_read(input logic [AW-1:0] a);
        for (int i = 0; i < NR; i++) if (a == BASE + AW'(i)) return m_held[i];
        return '0;
    endfunction

    task automatic check(input string t, input string what, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
        end
    endtask

    task automatic check_all();
        check(tag, "snap_taken", RW'(snap_taken), RW'(m_taken));
        check(tag, "snap_coincide", RW'(snap_coincide), RW'(m_coin));
        for (int i = 0; i < NR + 1; i++) begin
            rd_addr = BASE + AW'(i);
            #1;
            check(i == NR ? "R8" : tag, "rd_data", rd_data, exp_read(rd_addr));
        end
        rd_addr = 8'h10;
        #1;
        check("R8", "rd_data out of window", rd_data, '0);
    endtask

    // One clock: predict from the inputs the edge will sample, then compare.
    task automatic cycle();
        logic sel, wr_hit, irq_hit;
        logic [SS-1:0] n_sync;
        sel     = irq_src_sel ? irq_shared : irq_local;
        wr_hit  = wr_en && (wr_addr == LATCH);
        irq_hit = m_sync[SS-1] && !m_prev && irq_latch_en;
        n_sync  = {m_sync[SS-2:0], sel};
        @(posedge clk);
        #2;
        m_prev = m_sync[SS-1];
        m_sync = n_sync;
        if (wr_hit || irq_hit)
            for (int i = 0; i < NR; i++) m_held[i] = live_status[i*RW +: RW];
        m_taken = wr_hit || irq_hit;
        m_coin  = wr_hit && irq_hit;
        check_all();
    endtask

    task automatic new_live();
        for (int i = 0; i < NR; i++) live_status[i*RW +: RW] = RW'($urandom);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_fails++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NR; i++) m_held[i] = '0;
        new_live();
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        tag = "R9";
        check_all();                          // reset state

        tag = "R1";                           // latch write
        new_live(); wr_en = 1; wr_addr = LATCH; cycle(); wr_en = 0;
        tag = "R8"; new_live(); cycle(); cycle(); // live moves, held stays

        tag = "R2";                           // other addresses
        wr_en = 1; wr_addr = 8'h81; cycle(); wr_addr = BASE; cycle(); wr_en = 0;

        tag = "R3";                           // qualified local edge
        new_live(); irq_local = 1; repeat (SS + 2) cycle();
        tag = "R5"; new_live(); repeat (4) cycle();   // held high
        irq_local = 0; repeat (4) cycle();            // falling

        tag = "R4";                           // disabled edge, write still works
        irq_latch_en = 0; irq_local = 1; new_live(); repeat (SS + 2) cycle();
        wr_en = 1; wr_addr = LATCH; cycle(); wr_en = 0; cycle();
        irq_local = 0; repeat (SS + 1) cycle(); irq_latch_en = 1;

        tag = "R6";                           // shared line, local ignored
        irq_src_sel = 1; repeat (SS + 1) cycle();
        new_live(); irq_local = 1; repeat (SS + 2) cycle();
        irq_shared = 1; repeat (SS + 2) cycle();
        irq_shared = 0; irq_src_sel = 0; irq_local = 0; repeat (SS + 2) cycle();

        tag = "R7";                           // coincidence
        irq_local = 1; repeat (SS) cycle();
        new_live(); wr_en = 1; wr_addr = LATCH; cycle(); wr_en = 0;
        cycle(); irq_local = 0; repeat (SS + 1) cycle();

        tag = "R3";                           // random mix
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 3) == 0) new_live();
            wr_en   = ($urandom_range(0, 7) == 0);
            wr_addr = $urandom_range(0, 1) ? LATCH : AW'($urandom);
            if ($urandom_range(0, 5) == 0) irq_local  = ~irq_local;
            if ($urandom_range(0, 5) == 0) irq_shared = ~irq_shared;
            if ($urandom_range(0, 40) == 0) irq_src_sel  = ~irq_src_sel;
            if ($urandom_range(0, 30) == 0) irq_latch_en = ~irq_latch_en;
            cycle();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule